// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Stage

This block is the 16-bit arithmetic and logic stage that sits in front of an accumulator register, together with the one-bit link flag that extends it. Each cycle it receives a set of operation strobes from the control sequencer. These strobes are already decoded and gated. It also receives the data register operand and an 8-bit character from the input port. It then updates the accumulator and the link flag on the next clock edge. The block holds both registers and presents their contents at its outputs.

Nine accumulator operations are provided: bitwise AND, add, copy of the data register, copy of the input character into the low byte, bitwise invert, rotate right through the link, rotate left through the link, increment, and clear. Two further strobes act on the link flag alone: clear and invert. The block also drives the three register-control lines (load, increment, clear) that the selected operation implies. The surrounding datapath can observe these lines in the same cycle as the strobe.

Top module: `acc_alu_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, the accumulator reads 0x0000 and the link flag reads 0 until the first operation.
- R2: When `op_sel[0]` (AND) is high, the accumulator becomes the bitwise AND of itself and `dr_in` at the next clock edge. The link flag is unchanged.
- R3: When `op_sel[1]` (ADD) is high, the accumulator becomes the low 16 bits of the accumulator plus `dr_in`, and the link flag takes the carry out of bit 15.
- R4: When `op_sel[2]` is high, the accumulator is replaced by `dr_in`. When `op_sel[3]` is high, only bits 7:0 are replaced by `char_in` and bits 15:8 keep their value. Neither strobe changes the link flag.
- R5: When `op_sel[4]` is high, every accumulator bit is inverted.
- R6: When `op_sel[5]` is high, the accumulator rotates right by one through the link flag: the old link goes to bit 15 and the old bit 0 goes to the link.
- R7: When `op_sel[6]` is high, the accumulator rotates left by one through the link flag: the old link goes to bit 0 and the old bit 15 goes to the link.
- R8: When `op_sel[7]` is high, the accumulator increments by one, wrapping from 0xFFFF to 0x0000, and the link flag is unchanged.
- R9: When `op_sel[8]` is high, the accumulator becomes 0x0000.
- R10: `e_clear` forces the link flag to 0 and `e_flip` inverts it. If both are high, `e_clear` wins. If ADD or a rotate is active in the same cycle, that operation's value for the link overrides both.
- R11: With `op_sel` all zero and neither link strobe high, the accumulator and the link flag keep their values.
- R12: In the same cycle as the strobe, `ac_incr` is high exactly when `op_sel[7]` is high, `ac_zero` is high exactly when `op_sel[8]` is high, and `ac_load` is high exactly when any of `op_sel[6:0]` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 9 | One-hot operation strobes, bit positions as in R2 to R9 |
| e_clear | input | 1 | Clear the link flag |
| e_flip | input | 1 | Invert the link flag |
| dr_in | input | 16 | Data register operand |
| char_in | input | 8 | Input character |
| ac_q | output | 16 | Accumulator contents |
| e_q | output | 1 | Link flag contents |
| ac_load | output | 1 | Accumulator parallel-load control |
| ac_incr | output | 1 | Accumulator increment control |
| ac_zero | output | 1 | Accumulator clear control |

## Verification
The accumulator and link flag are both visible at the ports one edge after any strobe. A wrong next-state value therefore shows up on the very next cycle, with nothing buffered in between. A fault in the link path, such as a carry dropped or a rotate filling with zero, spreads into later rotates and adds. A scoreboard that compares every cycle, including idle cycles, catches it at once and catches its effects again later. Faults in the control decode show up as control lines that disagree with the strobe in the same cycle, or as an accumulator that fails to update.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned OP_N   = 9;
  localparam int unsigned OP_AND = 0;
  localparam int unsigned OP_ADD = 1;
  localparam int unsigned OP_LDR = 2;
  localparam int unsigned OP_LIN = 3;
  localparam int unsigned OP_CMP = 4;
  localparam int unsigned OP_SHR = 5;
  localparam int unsigned OP_SHL = 6;
  localparam int unsigned OP_INC = 7;
  localparam int unsigned OP_CLR = 8;

  // Sum with carry: {carry, sum}
  function automatic logic [16:0] fn_add16(input logic [15:0] a, input logic [15:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // Rotate right through link: {new_link, new_acc}
  function automatic logic [16:0] fn_rot_r(input logic [15:0] a, input logic lk);
    return {a[0], lk, a[15:1]};
  endfunction

  // Rotate left through link: {new_link, new_acc}
  function automatic logic [16:0] fn_rot_l(input logic [15:0] a, input logic lk);
    return {a[15], a[14:0], lk};
  endfunction

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_N-1:0] op_sel,
  output logic            ac_load,
  output logic            ac_incr,
  output logic            ac_zero
);

  logic [OP_N-1:0] load_mask;

  always_comb begin
    load_mask = '0;
    for (int i = 0; i < OP_N; i++) begin
      load_mask[i] = (i != OP_INC) && (i != OP_CLR);
    end
  end

  assign ac_load = |(op_sel & load_mask);
  assign ac_incr = op_sel[OP_INC];
  assign ac_zero = op_sel[OP_CLR];

  // R12
  ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(op_sel) |-> $onehot0({ac_load, ac_incr, ac_zero}));

  // R12
  ctrl_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|op_sel) |-> (ac_load || ac_incr || ac_zero));

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 8
) (
  input  logic [OP_N-1:0] op_sel,
  input  logic            e_clear,
  input  logic            e_flip,
  input  logic [W-1:0]    ac,
  input  logic [W-1:0]    dr,
  input  logic [CW-1:0]   chr,
  input  logic            e_cur,
  output logic [W-1:0]    ac_nxt,
  output logic            e_nxt,
  output logic            e_from_op
);

  logic [16:0] add_r, rr_r, rl_r;
  logic [W-1:0] chr_merge;

  assign add_r = fn_add16(ac, dr);
  assign rr_r  = fn_rot_r(ac, e_cur);
  assign rl_r  = fn_rot_l(ac, e_cur);

  generate
    if (CW < W) begin : g_merge
      assign chr_merge = {ac[W-1:CW], chr};
    end else begin : g_full
      assign chr_merge = chr[W-1:0];
    end
  endgenerate

  always_comb begin
    ac_nxt = ac;
    unique case (1'b1)
      op_sel[OP_AND]: ac_nxt = ac & dr;
      op_sel[OP_ADD]: ac_nxt = add_r[W-1:0];
      op_sel[OP_LDR]: ac_nxt = dr;
      op_sel[OP_LIN]: ac_nxt = chr_merge;
      op_sel[OP_CMP]: ac_nxt = ~ac;
      op_sel[OP_SHR]: ac_nxt = rr_r[W-1:0];
      op_sel[OP_SHL]: ac_nxt = rl_r[W-1:0];
      op_sel[OP_INC]: ac_nxt = ac + 1'b1;
      op_sel[OP_CLR]: ac_nxt = '0;
      default:        ac_nxt = ac;
    endcase
  end

  assign e_from_op = op_sel[OP_ADD] | op_sel[OP_SHR] | op_sel[OP_SHL];

  always_comb begin
    if (op_sel[OP_ADD])      e_nxt = add_r[16];
    else if (op_sel[OP_SHR]) e_nxt = rr_r[16];
    else if (op_sel[OP_SHL]) e_nxt = rl_r[16];
    else if (e_clear)        e_nxt = 1'b0;
    else if (e_flip)         e_nxt = ~e_cur;
    else                     e_nxt = e_cur;
  end

endmodule

// File: rtl/acc_alu_top.sv
module acc_alu_top
  import acc_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_N-1:0] op_sel,
  input  logic            e_clear,
  input  logic            e_flip,
  input  logic [15:0]     dr_in,
  input  logic [7:0]      char_in,
  output logic [15:0]     ac_q,
  output logic            e_q,
  output logic            ac_load,
  output logic            ac_incr,
  output logic            ac_zero
);

  localparam int unsigned W  = 16;
  localparam int unsigned CW = 8;

  logic [W-1:0] ac_nxt;
  logic         e_nxt;
  logic         e_from_op;
  logic         ac_we;

  acc_alu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .ac_load (ac_load),
    .ac_incr (ac_incr),
    .ac_zero (ac_zero)
  );

  acc_alu_logic #(.W(W), .CW(CW)) u_logic (
    .op_sel    (op_sel),
    .e_clear   (e_clear),
    .e_flip    (e_flip),
    .ac        (ac_q),
    .dr        (dr_in),
    .chr       (char_in),
    .e_cur     (e_q),
    .ac_nxt    (ac_nxt),
    .e_nxt     (e_nxt),
    .e_from_op (e_from_op)
  );

  assign ac_we = ac_load | ac_incr | ac_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q <= '0;
      e_q  <= 1'b0;
    end else begin
      if (ac_we) ac_q <= ac_nxt;
      e_q <= e_nxt;
    end
  end

  // R11
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == '0 && !e_clear && !e_flip) |=> ($stable(ac_q) && $stable(e_q)));

  // R9
  clr_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[OP_CLR] |=> (ac_q == '0));

  // R8
  inc_keeps_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel[OP_INC] && !e_clear && !e_flip) |=> $stable(e_q));

  // R4
  lin_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[OP_LIN] |=> (ac_q[15:8] == $past(ac_q[15:8])));

  // R6
  rot_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[OP_SHR] |=> (ac_q[15] == $past(e_q) && e_q == $past(ac_q[0])));

  // R7
  rot_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[OP_SHL] |=> (ac_q[0] == $past(e_q) && e_q == $past(ac_q[15])));

  // R5
  cmp_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel[OP_CMP] |=> (ac_q == ~$past(ac_q)));

  // R10
  e_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clear && !e_from_op) |=> !e_q);

endmodule

// File: tb/sim_acc_alu_top.sv
`timescale 1ns/1ps
module sim_acc_alu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  op_sel = '0;
  logic        e_clear = 1'b0;
  logic        e_flip = 1'b0;
  logic [15:0] dr_in = '0;
  logic [7:0]  char_in = '0;
  logic [15:0] ac_q;
  logic        e_q;
  logic        ac_load, ac_incr, ac_zero;

  int checks = 0;
  int failures = 0;

  logic [15:0] m_ac = 16'h0;
  logic        m_e  = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  acc_alu_top u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .e_clear(e_clear), .e_flip(e_flip),
    .dr_in(dr_in), .char_in(char_in), .ac_q(ac_q), .e_q(e_q),
    .ac_load(ac_load), .ac_incr(ac_incr), .ac_zero(ac_zero)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare registered state after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [16:0] ex;
      string t;
      ex = exp_q.pop_front();
      t  = tag_q.pop_front();
      check({e_q, ac_q} === ex, t, {15'd0, e_q, ac_q}, {15'd0, ex});
    end
  end

  // Driver: apply one cycle of stimulus, update model, push expectation
  task automatic drive(input int op, input logic [15:0] d, input logic [7:0] c,
                       input bit ecl, input bit efl, input string tag);
    logic [15:0] na;
    logic        ne;
    logic [31:0] s;
    @(negedge clk);
    op_sel  = (op >= 0) ? (9'd1 << op) : 9'd0;
    dr_in   = d;
    char_in = c;
    e_clear = ecl;
    e_flip  = efl;
    na = m_ac;
    ne = ecl ? 1'b0 : (efl ? ~m_e : m_e);
    case (op)
      0: na = m_ac & d;
      1: begin s = 32'(m_ac) + 32'(d); na = s[15:0]; ne = s[16]; end
      2: na = d;
      3: na = {m_ac[15:8], c};
      4: na = m_ac ^ 16'hFFFF;
      5: begin na = {m_e, m_ac[15:1]}; ne = m_ac[0]; end
      6: begin na = {m_ac[14:0], m_e}; ne = m_ac[15]; end
      7: na = 16'(32'(m_ac) + 1);
      8: na = 16'h0;
      default: ;
    endcase
    m_ac = na;
    m_e  = ne;
    exp_q.push_back({ne, na});
    tag_q.push_back(tag);
    #1;
    // R12 same-cycle control lines
    check(ac_incr === (op == 7), "R12 incr", {31'd0, ac_incr}, {31'd0, op == 7});
    check(ac_zero === (op == 8), "R12 zero", {31'd0, ac_zero}, {31'd0, op == 8});
    check(ac_load === (op >= 0 && op <= 6), "R12 load", {31'd0, ac_load},
          {31'd0, (op >= 0 && op <= 6)});
  endtask

  // Set AC and E to given values through the normal ops
  task automatic preset(input logic [15:0] a, input bit e);
    drive(2, a, 8'h00, 1'b1, 1'b0, "R4 load dr");
    if (e) drive(-1, 16'h0, 8'h00, 1'b0, 1'b1, "R10 flip");
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ac_q === 16'h0 && e_q === 1'b0, "R1 reset", {15'd0, e_q, ac_q}, 32'd0);
    rst_n = 1'b1;
    drive(-1, 16'h0, 8'h00, 1'b0, 1'b0, "R1 after reset");

    // Directed corners
    preset(16'hFFFF, 1'b0);
    drive(1, 16'h0001, 8'h00, 1'b0, 1'b0, "R3 add carry");
    preset(16'h1234, 1'b1);
    drive(1, 16'h0001, 8'h00, 1'b0, 1'b0, "R3 add no carry");
    preset(16'hFFFF, 1'b1);
    drive(7, 16'h0, 8'h00, 1'b0, 1'b0, "R8 inc wrap");
    preset(16'hABCD, 1'b0);
    drive(3, 16'h0, 8'h5A, 1'b0, 1'b0, "R4 char low byte");
    preset(16'h8001, 1'b1);
    drive(5, 16'h0, 8'h00, 1'b0, 1'b0, "R6 rotr");
    drive(6, 16'h0, 8'h00, 1'b0, 1'b0, "R7 rotl");
    drive(6, 16'h0, 8'h00, 1'b0, 1'b0, "R7 rotl 2");
    drive(0, 16'h0F0F, 8'h00, 1'b0, 1'b0, "R2 and");
    drive(4, 16'h0, 8'h00, 1'b0, 1'b0, "R5 cmp");
    drive(8, 16'h0, 8'h00, 1'b0, 1'b0, "R9 clr");
    drive(-1, 16'h0, 8'h00, 1'b1, 1'b1, "R10 clear wins");
    drive(-1, 16'h0, 8'h00, 1'b0, 1'b1, "R10 flip");
    preset(16'h8000, 1'b0);
    drive(6, 16'h0, 8'h00, 1'b1, 1'b1, "R10 rotate overrides");
    drive(-1, 16'hFFFF, 8'hFF, 1'b0, 1'b0, "R11 hold");
    drive(-1, 16'h1111, 8'h22, 1'b0, 1'b0, "R11 hold 2");

    // Random sweep over every operation
    for (int k = 0; k < 40; k++) begin
      for (int op = 0; op < 9; op++) begin
        preset(16'($urandom), 1'($urandom));
        drive(op, 16'($urandom), 8'($urandom), 1'b0, 1'b0,
              $sformatf("R2-R9 rnd op%0d", op));
      end
      drive(-1, 16'($urandom), 8'($urandom), 1'b0, 1'b0, "R11 rnd hold");
    end

    drive(-1, 16'h0, 8'h00, 1'b0, 1'b0, "R11 final");
    @(negedge clk);
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule